// File: doc/BRIEF.md
# Hot-Plug Fault Reporter

This block collects already-qualified fault events from a two-rail hot-plug power controller and reports them in one of two ways. The events are undervoltage on the 12 V, 3.3 V and auxiliary supplies, fast and slow overcurrent trips with a slow-trip filter timeout per rail, and two over-temperature flags. In register mode, the events are captured in sticky status bits. Software reads these bits and clears them by writing a 1. An active-low interrupt, gated by a mask bit, signals that a fault is pending. In pin mode, the register latches are not used. Instead, a small state machine drives one latched active-low fault pin, gated by the ON and AUXEN enable inputs.

A diagnostic force-on request switches the rail outputs on and holds the power-good indication off. While the request is active, it suppresses all fault capture. A control bit can disable the request. A plain write/read register port takes the place of the serial host bus.

The pin-mode state machine has four states:

- `PF_OFF`: no enable is asserted.
- `PF_WATCH`: enabled, with no fault present.
- `PF_TRIP`: a fault has been latched, so the fault pin is driven low.
- `PF_FORCE`: force-on is active.

It has the following transitions:

- **arm**: `PF_OFF` to `PF_WATCH` when an enable rises and no fault is present.
- **trip**: `PF_OFF` or `PF_WATCH` to `PF_TRIP` when an enable is asserted and a fault is present.
- **disarm**: any state to `PF_OFF` when both enables are low.
- **override**: any state to `PF_FORCE` while force-on is honoured.
- **resume**: `PF_FORCE` to `PF_WATCH`, `PF_TRIP` or `PF_OFF` once the force ends. The target follows the enables and the fault condition. A trip that was latched before the force is not restored.
- **leave**: any state to `PF_OFF` when register mode is selected.

Top module: `hp_fault_report`

## Requirements
- R1: After reset, all fault bits read 0, the control register reads 0 and the common-status register reads 0x08 (mask set). `irq_n` and `pin_fault_n` are 1.
- R2: Each fault bit is set on the clock edge that samples its condition.
  - Status (address 0) bit 4 is set by a 12 V fault (rail index 0), bit 2 by a 3.3 V fault (index 1) and bit 0 by an auxiliary fault (index 2). A rail fault is undervoltage, a fast overcurrent, or a slow overcurrent whose filter has timed out.
  - Common-status (address 2) bit 2 is set by a slow overcurrent on any rail together with `slot_ot`.
  - Common-status bit 1 is set by `die_ot`.
- R3: In register mode, a fault bit sets only while control (address 1) bit 1 (main enable) or bit 0 (aux enable) is 1. In pin mode, only `on_pin` or `auxen_pin` can arm the fault pin. No fault bit sets in pin mode.
- R4: A fault bit stays set until a write of 1 to its position at its address. Writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R5: In register mode, `irq_n` is 0 while common-status bit 3 (mask) is 0 and any fault bit is set. It is 1 when the mask is 1, and 1 in pin mode.
- R6: In register mode, `pin_fault_n` stays 1 and status bit 7 (summary flag) reads 0.
- R7: In pin mode, `pin_fault_n` goes to 0 one cycle after a qualifying fault is sampled while `on_pin` or `auxen_pin` is 1. Status bit 7 then reads 1. Both stay set, whatever the fault does, until both enables are 0.
- R8: Control bit 2 is the force disable.
  - When it is 0, `force_req` drives `force_on` and `pg_suppress` to 1, releases `pin_fault_n` and blocks all fault capture.
  - When it is 1, `force_req` has no effect.
- R9: Reads are combinational: address 0 is status, 1 is control (bits 2:0), 2 is common status (bits 3:1) and 3 reads 0. Reserved bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_mode | input | 1 | 1 selects pin-controlled reporting, 0 selects register mode |
| on_pin | input | 1 | Main rail enable pin |
| auxen_pin | input | 1 | Auxiliary rail enable pin |
| force_req | input | 1 | Diagnostic force-on request |
| uv | input | 3 | Undervoltage flags, index 0 = 12 V, 1 = 3.3 V, 2 = aux |
| oc_fast | input | 3 | Fast overcurrent trips per rail |
| oc_slow | input | 3 | Slow overcurrent trips per rail |
| filt_done | input | 3 | Slow-trip filter timeout per rail |
| slot_ot | input | 1 | Slot temperature above 140 °C |
| die_ot | input | 1 | Global die temperature above 160 °C |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| irq_n | output | 1 | Active-low interrupt (0 = asserted) |
| pin_fault_n | output | 1 | Active-low latched fault pin |
| force_on | output | 1 | Force all rail outputs on |
| pg_suppress | output | 1 | Hold the power-good indication deasserted |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a 2-bit address. With these values, every address, including the unmapped one, and every reserved read bit can be reached by a sweep. A behavioural model is stepped alongside the design and compared on every clock. Directed sequences cover the same-cycle set/clear race, the force disable, and pin-mode trips that outlive the fault while either enable stays high. A pseudo-random phase then mixes mode changes, register writes and fault inputs.

// File: rtl/hp_fault_pkg.sv
`timescale 1ns/1ps
package hp_fault_pkg;

    localparam int RAILS = 3;
    localparam int NFLT  = RAILS + 2;

    localparam int ADR_STAT  = 0;
    localparam int ADR_CTRL  = 1;
    localparam int ADR_CSTAT = 2;

    localparam int ST_SUM   = 7;
    localparam int CS_MASK  = 3;
    localparam int CT_AUX   = 0;
    localparam int CT_MAIN  = 1;
    localparam int CT_FDIS  = 2;
    localparam int CT_W     = 3;

    typedef enum logic [1:0] {
        PF_OFF   = 2'd0,
        PF_WATCH = 2'd1,
        PF_TRIP  = 2'd2,
        PF_FORCE = 2'd3
    } pin_st_t;

    // fault slot s -> bit position in its register
    function automatic int flt_bit(input int s);
        case (s)
            0:       return 4;
            1:       return 2;
            2:       return 0;
            3:       return 2;
            default: return 1;
        endcase
    endfunction

    // fault slot s lives in common status (1) or status (0)
    function automatic logic flt_in_cs(input int s);
        return (s >= RAILS);
    endfunction

endpackage

// File: rtl/hp_fault_qualify.sv
`timescale 1ns/1ps
module hp_fault_qualify #(
    parameter int NRAIL = 3
) (
    input  logic [NRAIL-1:0] uv,
    input  logic [NRAIL-1:0] oc_fast,
    input  logic [NRAIL-1:0] oc_slow,
    input  logic [NRAIL-1:0] filt_done,
    input  logic             slot_ot,
    input  logic             die_ot,
    output logic [NRAIL+1:0] cond
);

    genvar g;
    generate
        for (g = 0; g < NRAIL; g++) begin : g_rail
            assign cond[g] = uv[g] | oc_fast[g] | (oc_slow[g] & filt_done[g]);
        end
    endgenerate

    assign cond[NRAIL]   = slot_ot & (|oc_slow);
    assign cond[NRAIL+1] = die_ot;

endmodule

// File: rtl/hp_fault_latch.sv
`timescale 1ns/1ps
module hp_fault_latch #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic qb;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) qb <= 1'b0;
                else        qb <= set[g] | (qb & ~clr[g]);
            end
            assign q[g] = qb;
        end
    endgenerate

endmodule

// File: rtl/hp_pin_fault_fsm.sv
`timescale 1ns/1ps
module hp_pin_fault_fsm
    import hp_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_mode,
    input  logic en,
    input  logic any_cond,
    input  logic forced,
    output logic trip
);

    pin_st_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PF_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (!pin_mode) begin
            st_d = PF_OFF;                       // leave
        end else if (forced) begin
            st_d = PF_FORCE;                     // override
        end else begin
            unique case (st_q)
                PF_OFF, PF_FORCE: begin          // arm / trip / resume
                    if (!en)           st_d = PF_OFF;
                    else if (any_cond) st_d = PF_TRIP;
                    else               st_d = PF_WATCH;
                end
                PF_WATCH: begin
                    if (!en)           st_d = PF_OFF;   // disarm
                    else if (any_cond) st_d = PF_TRIP;  // trip
                end
                PF_TRIP: begin
                    if (!en)           st_d = PF_OFF;   // disarm
                end
                default: st_d = PF_OFF;
            endcase
        end
    end

    always_comb begin
        trip = (st_q == PF_TRIP);
    end

endmodule

// File: rtl/hp_fault_regs.sv
`timescale 1ns/1ps
module hp_fault_regs
    import hp_fault_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [NFLT-1:0] flt_q,
    input  logic            trip,
    output logic [CT_W-1:0] ctl,
    output logic            mask,
    output logic [NFLT-1:0] clr,
    output logic [DW-1:0]   rdata
);

    localparam logic [AW-1:0] A_ST = AW'(ADR_STAT);
    localparam logic [AW-1:0] A_CT = AW'(ADR_CTRL);
    localparam logic [AW-1:0] A_CS = AW'(ADR_CSTAT);

    logic wr_st, wr_ct, wr_cs;
    assign wr_st = we && (addr == A_ST);
    assign wr_ct = we && (addr == A_CT);
    assign wr_cs = we && (addr == A_CS);

    genvar g;
    generate
        for (g = 0; g < NFLT; g++) begin : g_clr
            localparam int B = flt_bit(g);
            if (flt_in_cs(g)) begin : g_cs
                assign clr[g] = wr_cs & wdata[B];
            end else begin : g_st
                assign clr[g] = wr_st & wdata[B];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl  <= '0;
            mask <= 1'b1;
        end else begin
            if (wr_ct) ctl  <= wdata[CT_W-1:0];
            if (wr_cs) mask <= wdata[CS_MASK];
        end
    end

    logic [DW-1:0] st_img, cs_img, ct_img;

    always_comb begin
        st_img = '0;
        cs_img = '0;
        ct_img = '0;
        for (int s = 0; s < NFLT; s++) begin
            if (flt_in_cs(s)) cs_img[flt_bit(s)] = flt_q[s];
            else              st_img[flt_bit(s)] = flt_q[s];
        end
        st_img[ST_SUM]     = trip;
        cs_img[CS_MASK]    = mask;
        ct_img[CT_W-1:0]   = ctl;
        case (addr)
            A_ST:    rdata = st_img;
            A_CT:    rdata = ct_img;
            A_CS:    rdata = cs_img;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/hp_fault_report.sv
`timescale 1ns/1ps
module hp_fault_report
    import hp_fault_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_mode,
    input  logic          on_pin,
    input  logic          auxen_pin,
    input  logic          force_req,
    input  logic [2:0]    uv,
    input  logic [2:0]    oc_fast,
    input  logic [2:0]    oc_slow,
    input  logic [2:0]    filt_done,
    input  logic          slot_ot,
    input  logic          die_ot,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_n,
    output logic          pin_fault_n,
    output logic          force_on,
    output logic          pg_suppress
);

    logic [NFLT-1:0] cond, set_v, clr_v, flt_q;
    logic [CT_W-1:0] ctl;
    logic            mask, trip, forced, en_reg, en_pin, en_sel;

    hp_fault_qualify #(.NRAIL(RAILS)) u_qual (
        .uv(uv), .oc_fast(oc_fast), .oc_slow(oc_slow), .filt_done(filt_done),
        .slot_ot(slot_ot), .die_ot(die_ot), .cond(cond)
    );

    assign forced = force_req & ~ctl[CT_FDIS];
    assign en_reg = ctl[CT_MAIN] | ctl[CT_AUX];
    assign en_pin = on_pin | auxen_pin;
    assign en_sel = pin_mode ? en_pin : en_reg;
    assign set_v  = cond & {NFLT{~pin_mode & en_reg & ~forced}};

    hp_fault_latch #(.N(NFLT)) u_latch (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v), .q(flt_q)
    );

    hp_fault_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .flt_q(flt_q), .trip(trip), .ctl(ctl), .mask(mask), .clr(clr_v),
        .rdata(reg_rdata)
    );

    hp_pin_fault_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .en(en_pin),
        .any_cond(|cond), .forced(forced), .trip(trip)
    );

    assign irq_n       = ~(~pin_mode & ~mask & (|flt_q));
    assign pin_fault_n = ~trip;
    assign force_on    = forced;
    assign pg_suppress = forced;

endmodule

// File: rtl/hp_fault_report_chk.sv
`timescale 1ns/1ps
module hp_fault_report_chk
    import hp_fault_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            pin_mode,
    input logic            reg_we,
    input logic            en_sel,
    input logic            forced,
    input logic            mask,
    input logic [NFLT-1:0] flt_q,
    input logic            irq_n,
    input logic            pin_fault_n
);

    assert_no_set_unarmed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_sel || pin_mode) |=> ((flt_q & ~$past(flt_q)) == '0));

    assert_hold_without_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((~flt_q & $past(flt_q)) == '0));

    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> irq_n);

    assert_pin_idle_reg_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_mode |=> pin_fault_n);

    assert_pin_trip_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_fault_n && pin_mode && en_sel && !forced) |=> !pin_fault_n);

    assert_no_set_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        forced |=> ((flt_q & ~$past(flt_q)) == '0));

endmodule

bind hp_fault_report hp_fault_report_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .reg_we(reg_we),
    .en_sel(en_sel), .forced(forced), .mask(mask), .flt_q(flt_q),
    .irq_n(irq_n), .pin_fault_n(pin_fault_n)
);

// File: tb/sim_hp_fault_report.sv
`timescale 1ns/1ps
module sim_hp_fault_report;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_mode = 1'b0, on_pin = 1'b0, auxen_pin = 1'b0, force_req = 1'b0;
    logic [2:0] uv = '0, oc_fast = '0, oc_slow = '0, filt_done = '0;
    logic       slot_ot = 1'b0, die_ot = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n, pin_fault_n, force_on, pg_suppress;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    bit m_st4, m_st2, m_st0, m_cs2, m_cs1, m_mask, m_trip;
    bit [2:0] m_ctl;

    hp_fault_report #(.DW(8), .AW(2)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_mode(pin_mode), .on_pin(on_pin),
        .auxen_pin(auxen_pin), .force_req(force_req), .uv(uv), .oc_fast(oc_fast),
        .oc_slow(oc_slow), .filt_done(filt_done), .slot_ot(slot_ot), .die_ot(die_ot),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n), .pin_fault_n(pin_fault_n),
        .force_on(force_on), .pg_suppress(pg_suppress)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {m_trip, 2'b00, m_st4, 1'b0, m_st2, 1'b0, m_st0};
            2'd1:    return {5'b0, m_ctl};
            2'd2:    return {4'b0, m_mask, m_cs2, m_cs1, 1'b0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        bit fr, anyl;
        fr   = force_req && !m_ctl[2];
        anyl = m_st4 | m_st2 | m_st0 | m_cs2 | m_cs1;
        chk("R5", irq_n, !(!pin_mode && !m_mask && anyl));
        chk("R7", pin_fault_n, !m_trip);
        chk("R8", force_on, fr);
        chk("R8", pg_suppress, fr);
        chk("R9", reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic tick();
        bit fr, g, en_p, anyc, c12, c3, caux, cslot, cdie, w0, w1, w2;
        bit n4, n2, n0, nc2, nc1, nm, nt;
        bit [2:0] nctl;
        fr    = force_req && !m_ctl[2];
        c12   = uv[0] | oc_fast[0] | (oc_slow[0] & filt_done[0]);
        c3    = uv[1] | oc_fast[1] | (oc_slow[1] & filt_done[1]);
        caux  = uv[2] | oc_fast[2] | (oc_slow[2] & filt_done[2]);
        cslot = slot_ot && (oc_slow != 3'b000);
        cdie  = die_ot;
        anyc  = c12 | c3 | caux | cslot | cdie;
        g     = !pin_mode && (m_ctl[1] || m_ctl[0]) && !fr;
        w0    = reg_we && reg_addr == 2'd0;
        w1    = reg_we && reg_addr == 2'd1;
        w2    = reg_we && reg_addr == 2'd2;
        n4    = (g && c12)   || (m_st4 && !(w0 && reg_wdata[4]));
        n2    = (g && c3)    || (m_st2 && !(w0 && reg_wdata[2]));
        n0    = (g && caux)  || (m_st0 && !(w0 && reg_wdata[0]));
        nc2   = (g && cslot) || (m_cs2 && !(w2 && reg_wdata[2]));
        nc1   = (g && cdie)  || (m_cs1 && !(w2 && reg_wdata[1]));
        nm    = w2 ? reg_wdata[3] : m_mask;
        nctl  = w1 ? reg_wdata[2:0] : m_ctl;
        en_p  = on_pin || auxen_pin;
        nt    = pin_mode && !fr && en_p && (m_trip || anyc);
        @(posedge clk);
        m_st4 = n4; m_st2 = n2; m_st0 = n0; m_cs2 = nc2; m_cs1 = nc1;
        m_mask = nm; m_ctl = nctl; m_trip = nt;
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input string tag, input logic [7:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic quiet();
        uv = '0; oc_fast = '0; oc_slow = '0; filt_done = '0; slot_ot = 0; die_ot = 0;
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lf;
        m_mask = 1; m_ctl = 0; m_trip = 0;
        m_st4 = 0; m_st2 = 0; m_st0 = 0; m_cs2 = 0; m_cs1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        rd(2'd0, "R1", 8'h00);
        rd(2'd1, "R1", 8'h00);
        rd(2'd2, "R1", 8'h08);
        chk("R1", irq_n, 1'b1);
        chk("R1", pin_fault_n, 1'b1);

        // R3: no enable, no latch
        uv[0] = 1; tick(); quiet();
        rd(2'd0, "R3", 8'h00);

        // R2 12 V fault with main enable
        wr(2'd1, 8'h02);
        uv[0] = 1; tick(); quiet();
        rd(2'd0, "R2", 8'h10);
        chk("R5", irq_n, 1'b1);
        chk("R6", pin_fault_n, 1'b1);
        wr(2'd2, 8'h00);
        chk("R5", irq_n, 1'b0);
        wr(2'd0, 8'h00);
        rd(2'd0, "R4", 8'h10);
        wr(2'd0, 8'h10);
        rd(2'd0, "R4", 8'h00);
        chk("R5", irq_n, 1'b1);

        // R2 per-bit mapping
        oc_fast[1] = 1; tick(); quiet();
        rd(2'd0, "R2", 8'h04);
        wr(2'd0, 8'h04);
        oc_slow[2] = 1; tick();
        rd(2'd0, "R2", 8'h00);
        filt_done[2] = 1; tick(); quiet();
        rd(2'd0, "R2", 8'h01);
        wr(2'd0, 8'h01);
        oc_slow[0] = 1; slot_ot = 1; tick(); quiet();
        rd(2'd2, "R2", 8'h04);
        rd(2'd0, "R2", 8'h00);
        die_ot = 1; tick(); quiet();
        rd(2'd2, "R2", 8'h06);
        wr(2'd2, 8'h06);
        rd(2'd2, "R4", 8'h00);

        // R4 set wins over same-cycle clear
        uv[0] = 1; wr(2'd0, 8'h10); quiet();
        rd(2'd0, "R4", 8'h10);
        wr(2'd0, 8'h10);
        rd(2'd0, "R4", 8'h00);

        // R8 force honoured, then disabled
        force_req = 1; #0.5;
        chk("R8", force_on, 1'b1);
        chk("R8", pg_suppress, 1'b1);
        uv[0] = 1; tick(); quiet();
        rd(2'd0, "R8", 8'h00);
        force_req = 0;
        wr(2'd1, 8'h06);
        force_req = 1; #0.5;
        chk("R8", force_on, 1'b0);
        uv[0] = 1; tick(); quiet();
        rd(2'd0, "R8", 8'h10);
        force_req = 0;
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h00);

        // R7 pin mode
        pin_mode = 1; uv[0] = 1; tick();
        chk("R3", pin_fault_n, 1'b1);
        on_pin = 1; tick();
        chk("R7", pin_fault_n, 1'b0);
        rd(2'd0, "R7", 8'h80);
        quiet(); tick();
        chk("R7", pin_fault_n, 1'b0);
        on_pin = 0; auxen_pin = 1; tick();
        chk("R7", pin_fault_n, 1'b0);
        auxen_pin = 0; tick();
        chk("R7", pin_fault_n, 1'b1);
        on_pin = 1; die_ot = 1; tick();
        chk("R7", pin_fault_n, 1'b0);
        force_req = 1; tick();
        chk("R8", pin_fault_n, 1'b1);
        force_req = 0; quiet(); tick();
        chk("R8", pin_fault_n, 1'b1);
        on_pin = 0; pin_mode = 0; tick();

        // R9 map and reserved bits
        wr(2'd1, 8'hF8);
        rd(2'd1, "R9", 8'h00);
        rd(2'd3, "R9", 8'h00);
        wr(2'd2, 8'hF7);
        rd(2'd2, "R9", 8'h00);

        // mixed pseudo-random phase
        lf = 32'h1ACE_B00C;
        for (int i = 0; i < 3000; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            if ((i % 200) == 0) pin_mode = lf[5];
            on_pin    = lf[6] & lf[7];
            auxen_pin = lf[8] & lf[9] & lf[10];
            force_req = (lf[11:14] == 4'h0);
            uv        = lf[17:15] & {3{lf[18] & lf[19]}};
            oc_fast   = lf[22:20] & {3{lf[23] & lf[24]}};
            oc_slow   = lf[27:25] & {3{lf[28]}};
            filt_done = {lf[29], lf[30], lf[2]};
            slot_ot   = lf[3] & lf[4];
            die_ot    = (lf[31:29] == 3'b111);
            reg_we    = lf[12] & lf[13];
            reg_addr  = lf[1:0];
            reg_wdata = lf[23:16];
            tick();
        end
        reg_we = 0;

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule